// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps time of day and calendar date as a free-running counter. It holds seconds, minutes, hours, day of week, date, month and a two-digit year. Every field is presented on its own output byte in packed BCD, so a host can latch all seven bytes together as a snapshot. Time moves forward on a tick input. A prescaler turns `TICKS_PER_SEC` tick pulses into one second. Carries ripple through minutes, hours, day of week, date, month and year in the same clock edge.

Any field can be overwritten by a one-cycle write strobe with a 3-bit field index and a data byte. Each field masks the byte to its own bits. The hours byte chooses its own encoding: 24-hour, or 12-hour with an afternoon flag. The chosen encoding stays in force as time advances. Month lengths follow a fixed table, with a 29-day February in every year divisible by four (two-digit years, 2000 to 2099).

Internally the fields are kept in binary. The hour is always stored as 0 to 23, and it is rendered to BCD, or to 12-hour form, only at the outputs.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the outputs read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R2: With no write pending, seconds advance by one after every `TICKS_PER_SEC` tick pulses (4 by default). Cycles without a tick do not count. The result shows on the outputs right after the clock edge that takes the last pulse.
- R3: Seconds roll from 59 to 00 and then add one to minutes. Minutes roll from 59 to 00 and then add one to hours. Hours roll from 23 to 0 and then advance the day.
- R4: A write to index 0 loads seconds from data bits 6:0 as BCD. Bit 7 (clock halt) is dropped, and output bit 7 always reads 0. The same write restarts the sub-second tick count from zero.
- R5: Field masks on load are: index 1 minutes from bits 6:0, index 4 date from bits 5:0, index 5 month from bits 4:0, index 6 year from bits 7:0. All are BCD, and the output byte shows only the loaded value.
- R6: A write to index 2 with bit 6 = 0 selects 24-hour mode. The hour 0–23 is taken from bits 5:0 as BCD, and the hours output has bit 6 clear.
- R7: A write to index 2 with bit 6 = 1 selects 12-hour mode. Bit 5 is the afternoon flag and bits 4:0 hold the hour 1–12 in BCD. A loaded 12 with the flag clear means midnight (hour 0); a loaded 12 with the flag set means noon. The output shows 0x40 | flag<<5 | BCD(1–12): midnight reads 0x52, noon 0x72 and 13:00–23:00 read 0x61–0x71. The mode holds across ticks.
- R8: A write to index 3 loads day of week from bits 2:0, with valid values 1–7. Day of week advances at each midnight carry and goes from 7 to 1, regardless of the date.
- R9: At the midnight carry the date goes back to 01 once it has reached the month length: 31 for months 1, 3, 5, 7, 8, 10, 12; 30 for months 4, 6, 9, 11; 29 for February when year mod 4 is 0, else 28. Otherwise the date adds one.
- R10: A month rollover from 12 gives month 1 and adds one to the year. The year goes from 99 to 00.
- R11: In a cycle with the write strobe high, a tick is ignored: no field moves and the sub-second count holds. A write to index 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sub-second tick pulse |
| wr_en_i | input | 1 | Field write strobe |
| wr_idx_i | input | 3 | Field index: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 7 none |
| wr_data_i | input | 8 | Byte to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, 24-hour or 12-hour form |
| dow_o | output | 8 | Day of week 1–7 |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
A long stream of random writes and ticks is run against a bench model. The writes are biased toward 58/59 seconds, 59 minutes and the last hour, so that carries happen often. The stream also includes strobes that collide with ticks. This separates correct carry order and write priority from lost or doubled seconds. Directed sequences cover what random input rarely reaches:
- the end of a century, where every field wraps;
- February of a leap year against a common year, which tells the leap rule from a fixed 28-day month;
- a 30-day month;
- midnight and noon in 12-hour mode, which shows whether the 12 AM / 12 PM mapping is right.

A sequence of partial ticks followed by a seconds write shows whether the sub-second phase was really cleared.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    typedef enum logic [2:0] {
        IDX_SEC   = 3'd0,
        IDX_MIN   = 3'd1,
        IDX_HOUR  = 3'd2,
        IDX_DOW   = 3'd3,
        IDX_DATE  = 3'd4,
        IDX_MONTH = 3'd5,
        IDX_YEAR  = 3'd6,
        IDX_NONE  = 3'd7
    } cal_idx_e;

    // two BCD digits to binary 0..99
    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
    endfunction

    // binary 0..99 to two BCD digits
    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    // month length; year is binary 0..99 counted from 2000
    function automatic logic [4:0] days_in_month(input logic [3:0] m, input logic [6:0] y);
        logic [4:0] d;
        case (m)
            4'd2:                      d = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
            default:                   d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bcd_cal_prescaler.sv
module bcd_cal_prescaler #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic clear_i,
    output logic sec_step_o
);

    generate
        if (TICKS_PER_SEC <= 1) begin : g_direct
            assign sec_step_o = tick_i & ~hold_i;
        end else begin : g_count
            localparam int PW = $clog2(TICKS_PER_SEC);
            localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

            logic [PW-1:0] phase_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (clear_i) begin
                    phase_q <= '0;
                end else if (tick_i && !hold_i) begin
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
                end
            end

            assign sec_step_o = tick_i & ~hold_i & (phase_q == LAST);

            // R4: a seconds load restarts the sub-second phase
            assert_phase_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                clear_i |=> (phase_q == '0));

            // R11: a held cycle leaves the phase untouched
            assert_phase_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (hold_i && !clear_i) |=> $stable(phase_q));
        end
    endgenerate

endmodule

// File: rtl/bcd_cal_time.sv
module bcd_cal_time
    import bcd_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_step_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_idx_i,
    input  logic [6:0] wr_data_i,
    output logic [5:0] sec_o,
    output logic [5:0] min_o,
    output logic [4:0] hour_o,
    output logic       mode12_o,
    output logic       day_step_o
);

    logic [5:0] sec_q, min_q;
    logic [4:0] hour_q;
    logic       mode12_q;
    logic [6:0] h12_bin;
    logic [4:0] hour_load;

    // hour byte decode for either encoding
    always_comb begin
        h12_bin   = bcd_to_bin({3'b000, wr_data_i[4:0]});
        hour_load = 5'(bcd_to_bin({2'b00, wr_data_i[5:0]}));
        if (wr_data_i[6]) begin
            hour_load = (h12_bin == 7'd12) ? 5'd0 : h12_bin[4:0];
            if (wr_data_i[5]) begin
                hour_load = hour_load + 5'd12;
            end
        end
    end

    wire sec_wrap  = (sec_q == 6'd59);
    wire min_wrap  = (min_q == 6'd59);
    wire hour_wrap = (hour_q == 5'd23);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q    <= '0;
            min_q    <= '0;
            hour_q   <= '0;
            mode12_q <= 1'b0;
        end else if (wr_en_i) begin
            unique case (cal_idx_e'(wr_idx_i))
                IDX_SEC:  sec_q <= 6'(bcd_to_bin({1'b0, wr_data_i}));
                IDX_MIN:  min_q <= 6'(bcd_to_bin({1'b0, wr_data_i}));
                IDX_HOUR: begin
                    hour_q   <= hour_load;
                    mode12_q <= wr_data_i[6];
                end
                default: ;
            endcase
        end else if (sec_step_i) begin
            sec_q <= sec_wrap ? 6'd0 : sec_q + 6'd1;
            if (sec_wrap) begin
                min_q <= min_wrap ? 6'd0 : min_q + 6'd1;
                if (min_wrap) begin
                    hour_q <= hour_wrap ? 5'd0 : hour_q + 5'd1;
                end
            end
        end
    end

    assign day_step_o = sec_step_i & ~wr_en_i & sec_wrap & min_wrap & hour_wrap;
    assign sec_o      = sec_q;
    assign min_o      = min_q;
    assign hour_o     = hour_q;
    assign mode12_o   = mode12_q;

    // R3: seconds wrap carries into minutes
    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_step_i && !wr_en_i && sec_q == 6'd59 && min_q != 6'd59)
        |=> (sec_q == 6'd0 && min_q == $past(min_q) + 6'd1));

    // R3: the midnight carry leaves the clock at 00:00:00
    assert_midnight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        day_step_o |=> (hour_q == 5'd0 && min_q == 6'd0 && sec_q == 6'd0));

    // R7: the encoding chosen on load survives ticks
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_idx_i == 3'd2) |=> $stable(mode12_q));

endmodule

// File: rtl/bcd_cal_date.sv
module bcd_cal_date
    import bcd_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_step_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_idx_i,
    input  logic [7:0] wr_data_i,
    output logic [2:0] dow_o,
    output logic [4:0] date_o,
    output logic [3:0] month_o,
    output logic [6:0] year_o
);

    logic [2:0] dow_q;
    logic [4:0] date_q;
    logic [3:0] month_q;
    logic [6:0] year_q;
    logic [4:0] month_len;

    assign month_len = days_in_month(month_q, year_q);

    wire date_wrap  = (date_q >= month_len);
    wire month_wrap = (month_q == 4'd12);
    wire year_wrap  = (year_q == 7'd99);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dow_q   <= 3'd1;
            date_q  <= 5'd1;
            month_q <= 4'd1;
            year_q  <= 7'd0;
        end else if (wr_en_i) begin
            unique case (cal_idx_e'(wr_idx_i))
                IDX_DOW:   dow_q   <= wr_data_i[2:0];
                IDX_DATE:  date_q  <= 5'(bcd_to_bin({2'b00, wr_data_i[5:0]}));
                IDX_MONTH: month_q <= 4'(bcd_to_bin({3'b000, wr_data_i[4:0]}));
                IDX_YEAR:  year_q  <= bcd_to_bin(wr_data_i);
                default: ;
            endcase
        end else if (day_step_i) begin
            dow_q <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
            if (date_wrap) begin
                date_q  <= 5'd1;
                month_q <= month_wrap ? 4'd1 : month_q + 4'd1;
                if (month_wrap) begin
                    year_q <= year_wrap ? 7'd0 : year_q + 7'd1;
                end
            end else begin
                date_q <= date_q + 5'd1;
            end
        end
    end

    assign dow_o   = dow_q;
    assign date_o  = date_q;
    assign month_o = month_q;
    assign year_o  = year_q;

    // R8: day of week wraps 7 -> 1
    assert_dow_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (day_step_i && !wr_en_i && dow_q == 3'd7) |=> (dow_q == 3'd1));

    // R9: last day of the month returns to day 1 of the next
    assert_date_roll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (day_step_i && !wr_en_i && date_q >= month_len) |=> (date_q == 5'd1));

    // R10: century wrap
    assert_year_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (day_step_i && !wr_en_i && date_q >= month_len && month_q == 4'd12 && year_q == 7'd99)
        |=> (year_q == 7'd0 && month_q == 4'd1));

endmodule

// File: rtl/bcd_cal_encode.sv
module bcd_cal_encode
    import bcd_cal_pkg::*;
(
    input  logic [5:0] sec_i,
    input  logic [5:0] min_i,
    input  logic [4:0] hour_i,
    input  logic       mode12_i,
    input  logic [2:0] dow_i,
    input  logic [4:0] date_i,
    input  logic [3:0] month_i,
    input  logic [6:0] year_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);

    logic [4:0] h12;
    logic       pm;

    always_comb begin
        pm = (hour_i >= 5'd12);
        if (hour_i == 5'd0) begin
            h12 = 5'd12;
        end else if (hour_i > 5'd12) begin
            h12 = hour_i - 5'd12;
        end else begin
            h12 = hour_i;
        end
        if (mode12_i) begin
            hour_o = 8'h40 | (pm ? 8'h20 : 8'h00) | (bin_to_bcd({2'b00, h12}) & 8'h1F);
        end else begin
            hour_o = bin_to_bcd({2'b00, hour_i}) & 8'h3F;
        end
    end

    assign sec_o   = bin_to_bcd({1'b0, sec_i});
    assign min_o   = bin_to_bcd({1'b0, min_i});
    assign dow_o   = {5'b00000, dow_i};
    assign date_o  = bin_to_bcd({2'b00, date_i});
    assign month_o = bin_to_bcd({3'b000, month_i});
    assign year_o  = bin_to_bcd(year_i);

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
    import bcd_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_idx_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);

    logic       sec_step, day_step, mode12;
    logic [5:0] sec_b, min_b;
    logic [4:0] hour_b, date_b;
    logic [2:0] dow_b;
    logic [3:0] month_b;
    logic [6:0] year_b;

    bcd_cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .hold_i     (wr_en_i),
        .clear_i    (wr_en_i && wr_idx_i == 3'd0),
        .sec_step_o (sec_step)
    );

    bcd_cal_time u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_step_i (sec_step),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_idx_i),
        .wr_data_i  (wr_data_i[6:0]),
        .sec_o      (sec_b),
        .min_o      (min_b),
        .hour_o     (hour_b),
        .mode12_o   (mode12),
        .day_step_o (day_step)
    );

    bcd_cal_date u_date (
        .clk        (clk),
        .rst_n      (rst_n),
        .day_step_i (day_step),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_idx_i),
        .wr_data_i  (wr_data_i),
        .dow_o      (dow_b),
        .date_o     (date_b),
        .month_o    (month_b),
        .year_o     (year_b)
    );

    bcd_cal_encode u_enc (
        .sec_i    (sec_b),
        .min_i    (min_b),
        .hour_i   (hour_b),
        .mode12_i (mode12),
        .dow_i    (dow_b),
        .date_i   (date_b),
        .month_i  (month_b),
        .year_i   (year_b),
        .sec_o    (sec_o),
        .min_o    (min_o),
        .hour_o   (hour_o),
        .dow_o    (dow_o),
        .date_o   (date_o),
        .month_o  (month_o),
        .year_o   (year_o)
    );

    // R11: a write to another field blocks the tick from moving seconds
    assert_write_blocks_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i != 3'd0) |=> $stable(sec_o));

    // R11: index 7 leaves every output unchanged
    assert_idx7_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == 3'd7)
        |=> $stable({sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o}));

    // R7: a 12-hour reading never shows hour zero
    assert_hour12_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hour_o[6] |-> (hour_o[4:0] != 5'd0));

    // R4: bit 7 of seconds never reads back
    assert_sec_bit7_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o[7] == 1'b0);

endmodule

// File: tb/bcd_calendar_core_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_core_tb_top;

    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_idx_i = 3'd0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

    always #2.5 clk = ~clk;

    bcd_calendar_core #(.TICKS_PER_SEC(TPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    int errors = 0;
    int checks = 0;

    // bench model, binary
    int m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year, m_phase;
    bit m_mode12;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_hour();
        int h;
        logic [7:0] r;
        if (!m_mode12) return to_bcd(m_hour);
        h = m_hour % 12;
        if (h == 0) h = 12;
        r = 8'h40 | to_bcd(h);
        if (m_hour >= 12) r = r | 8'h20;
        return r;
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hour = 0; m_mode12 = 0;
        m_dow = 1; m_date = 1; m_mon = 1; m_year = 0; m_phase = 0;
    endtask

    task automatic model_second();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hour++;
        if (m_hour < 24) return;
        m_hour = 0;
        m_dow = m_dow % 7 + 1;
        if (m_date >= mdays(m_mon, m_year)) begin
            m_date = 1;
            if (m_mon == 12) begin
                m_mon = 1;
                m_year = (m_year + 1) % 100;
            end else begin
                m_mon++;
            end
        end else begin
            m_date++;
        end
    endtask

    task automatic model_cycle(input bit tk, input bit we, input int idx, input logic [7:0] d);
        int h;
        if (we) begin
            case (idx)
                0: begin m_sec = from_bcd(d & 8'h7F); m_phase = 0; end
                1: m_min = from_bcd(d & 8'h7F);
                2: begin
                    if (d[6]) begin
                        h = from_bcd(d & 8'h1F);
                        if (h == 12) h = 0;
                        if (d[5]) h += 12;
                        m_mode12 = 1;
                    end else begin
                        h = from_bcd(d & 8'h3F);
                        m_mode12 = 0;
                    end
                    m_hour = h;
                end
                3: m_dow = int'(d[2:0]);
                4: m_date = from_bcd(d & 8'h3F);
                5: m_mon = from_bcd(d & 8'h1F);
                6: m_year = from_bcd(d);
                default: ;
            endcase
        end else if (tk) begin
            if (m_phase == TPS - 1) begin
                m_phase = 0;
                model_second();
            end else begin
                m_phase++;
            end
        end
    endtask

    task automatic chk(input string tag, input string name, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "sec",   sec_o,   to_bcd(m_sec));
        chk(tag, "min",   min_o,   to_bcd(m_min));
        chk(tag, "hour",  hour_o,  exp_hour());
        chk(tag, "dow",   dow_o,   8'(m_dow));
        chk(tag, "date",  date_o,  to_bcd(m_date));
        chk(tag, "month", month_o, to_bcd(m_mon));
        chk(tag, "year",  year_o,  to_bcd(m_year));
    endtask

    task automatic cyc(input bit tk, input bit we, input int idx, input logic [7:0] d, input string tag);
        @(negedge clk);
        tick_i = tk; wr_en_i = we; wr_idx_i = 3'(idx); wr_data_i = d;
        @(posedge clk);
        model_cycle(tk, we, idx, d);
        #1;
        check_all(tag);
    endtask

    task automatic wr(input int idx, input logic [7:0] d, input string tag);
        cyc(1'b0, 1'b1, idx, d, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 0, 8'h00, tag);
    endtask

    task automatic set_all(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                           input logic [7:0] dw, input logic [7:0] hr, input logic [7:0] mi,
                           input logic [7:0] se, input string tag);
        wr(6, yr, tag); wr(5, mo, tag); wr(4, dt, tag); wr(3, dw, tag);
        wr(2, hr, tag); wr(1, mi, tag); wr(0, se, tag);
    endtask

    function automatic logic [7:0] rand_data(input int idx);
        logic [7:0] r;
        int v;
        r = 8'($urandom);
        case (idx)
            0: begin v = ($urandom % 3 == 0) ? 58 + int'($urandom % 2) : int'($urandom % 60);
                     return {r[7], 7'(to_bcd(v))}; end
            1: begin v = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
                     return {r[7], 7'(to_bcd(v))}; end
            2: begin
                if (r[0]) begin
                    v = ($urandom % 3 == 0) ? 11 : 1 + int'($urandom % 12);
                    return {r[7], 1'b1, r[1], 5'(to_bcd(v))};
                end
                v = ($urandom % 3 == 0) ? 23 : int'($urandom % 24);
                return {r[7], 1'b0, 6'(to_bcd(v))};
            end
            3: return {r[7:3], 3'(1 + $urandom % 7)};
            4: return {r[7:6], 6'(to_bcd(1 + int'($urandom % 28)))};
            5: return {r[7:5], 5'(to_bcd(1 + int'($urandom % 12)))};
            6: return to_bcd(int'($urandom % 100));
            default: return r;
        endcase
    endfunction

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R1");

        // R2: four ticks per second, gaps do not count
        ticks(3, "R2");
        cyc(1'b0, 1'b0, 0, 8'h00, "R2");
        ticks(5, "R2");

        // R4: bit 7 dropped, phase cleared by seconds load
        ticks(3, "R4");
        wr(0, 8'hC5, "R4");
        ticks(3, "R4");
        ticks(1, "R4");

        // R5: masks on minutes, date, month, year
        wr(1, 8'hA7, "R5");
        wr(4, 8'hD9, "R5");
        wr(5, 8'hE9, "R5");
        wr(6, 8'h47, "R5");

        // R6: 24-hour load ignoring bit 7
        wr(2, 8'h93, "R6");

        // R10 R8 R3: century end, all fields wrap
        set_all(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58, "R10");
        ticks(8, "R10");

        // R9: leap February, common February, 30-day month
        set_all(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59, "R9");
        ticks(4, "R9");
        wr(2, 8'h23, "R9"); wr(1, 8'h59, "R9"); wr(0, 8'h59, "R9");
        ticks(4, "R9");
        set_all(8'h23, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59, "R9");
        ticks(4, "R9");
        set_all(8'h23, 8'h04, 8'h30, 8'h06, 8'h23, 8'h59, 8'h59, "R9");
        ticks(4, "R9");

        // R7: 12 AM, 12 PM, 11 AM -> noon, 11 PM -> midnight
        wr(2, 8'h52, "R7");
        wr(2, 8'h72, "R7");
        wr(2, 8'h51, "R7"); wr(1, 8'h59, "R7"); wr(0, 8'h59, "R7");
        ticks(4, "R7");
        wr(2, 8'h71, "R7"); wr(1, 8'h59, "R7"); wr(0, 8'h59, "R7");
        ticks(4, "R7");
        ticks(40, "R7");

        // R11: write collides with the completing tick; index 7 ignored
        wr(0, 8'h10, "R11");
        ticks(3, "R11");
        cyc(1'b1, 1'b1, 1, 8'h22, "R11");
        cyc(1'b1, 1'b1, 7, 8'hFF, "R11");
        ticks(1, "R11");

        // random mix
        for (int i = 0; i < 6000; i++) begin
            int r;
            int idx;
            r = int'($urandom % 16);
            idx = int'($urandom % 8);
            if (r < 2)       cyc(1'b0, 1'b1, idx, rand_data(idx), "R3 R5 R6 R7 R8");
            else if (r < 3)  cyc(1'b1, 1'b1, idx, rand_data(idx), "R11");
            else if (r < 13) cyc(1'b1, 1'b0, 0, 8'h00, "R2 R3 R9");
            else             cyc(1'b0, 1'b0, 0, 8'h00, "R2");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule